// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block joins two independently clocked ports through a pair of first-in first-out queues that run in opposite directions. The forward queue takes words written on port A and hands them out on port B. The return queue takes words written on port B and hands them out on port A. Each port has one select, one direction bit, one mailbox-select bit and one enable. Together these pick whether a clock edge pushes a word into that port's outgoing queue, pops a word from its incoming queue, or does nothing.

Each queue keeps a full flag and an active-low almost-full flag in its writer's clock domain, and an empty flag in its reader's clock domain. The almost-full threshold is set by a per-queue margin parameter. Pointers cross between the clocks as Gray code through a multi-stage synchroniser. A flag that depends on the far side therefore updates a few cycles after the far-side access, and never early. A single asynchronous active-low reset returns both queues to empty.

Top module: `bdf_pair`

## Requirements
- R1: On a rising clk_a edge with a_sel_n=0, a_mbx=0 and a_en=1, a_dir=1 pushes a_din into the forward queue and a_dir=0 pops the return queue onto a_dout.
- R2: On a rising clk_b edge with b_sel_n=0, b_mbx=0 and b_en=1, b_dir=1 pops the forward queue onto b_dout and b_dir=0 pushes b_din into the return queue.
- R3: An edge with the port select high, the mailbox select high or the enable low neither pushes nor pops, and the port's data output keeps its value.
- R4: Each queue returns words in the order in which they were written, including when pushes and pops interleave.
- R5: A queue's full flag is high exactly while it holds DEPTH words once both sides have settled, and a push into a full queue is dropped.
- R6: A queue's empty flag is high exactly while it holds no words once both sides have settled, and a pop from an empty queue is dropped with the data output unchanged.
- R7: ab_afull_n is low while the forward queue holds at least DEPTH-AF_OFF_AB words and high while it holds DEPTH-AF_OFF_AB-1 or fewer.
- R8: ba_afull_n is low while the return queue holds at least DEPTH-AF_OFF_BA words and high while it holds DEPTH-AF_OFF_BA-1 or fewer.
- R9: After the reader-side pop that takes a queue below its almost-full level, its almost-full flag rises within four writer-clock edges. Three edges is the normal case, and a fourth covers edges that nearly coincide.
- R10: While rst_n is low, both empty flags are high, both full flags are low, both almost-full flags are high and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_sel_n | input | 1 | Port A select, active low |
| a_dir | input | 1 | Port A direction: 1 push forward, 0 pop return |
| a_mbx | input | 1 | Port A mailbox select; a high level blocks queue access |
| a_en | input | 1 | Port A enable |
| a_din | input | DW | Port A write data |
| a_dout | output | DW | Port A read data from the return queue |
| ab_full | output | 1 | Forward queue full (clk_a domain) |
| ab_afull_n | output | 1 | Forward queue almost full, active low (clk_a domain) |
| ba_empty | output | 1 | Return queue empty (clk_a domain) |
| b_sel_n | input | 1 | Port B select, active low |
| b_dir | input | 1 | Port B direction: 1 pop forward, 0 push return |
| b_mbx | input | 1 | Port B mailbox select; a high level blocks queue access |
| b_en | input | 1 | Port B enable |
| b_din | input | DW | Port B write data |
| b_dout | output | DW | Port B read data from the forward queue |
| ba_full | output | 1 | Return queue full (clk_b domain) |
| ba_afull_n | output | 1 | Return queue almost full, active low (clk_b domain) |
| ab_empty | output | 1 | Forward queue empty (clk_b domain) |

## Verification
The bench fills each queue one word at a time and drains it again. At every fill level it compares both flags with the arithmetic threshold. An off-by-one in the margin compare would move the almost-full transition by one word, and a wrong pointer width would report full at half depth or never. The bench times the almost-full release across the clock boundary with the two clocks at unrelated periods. A flag derived from an unsynchronised or stale pointer would rise too late or stick low. The bench also sends dropped accesses (push when full, pop when empty, mailbox-selected, deselected, disabled) and then checks the data order. A design that let any of these through would shift every later word or overwrite the output.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
   localparam int MIN_SYNC_STAGES = 2;

   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_PUSH = 2'd1,
      ACC_POP  = 2'd2
   } acc_e;
endpackage

// File: rtl/bdf_port_dec.sv
module bdf_port_dec
   import bdf_pkg::*;
#(
   parameter bit PUSH_ON_DIR = 1'b1
) (
   input  logic sel_n,
   input  logic dir,
   input  logic mbx,
   input  logic en,
   output acc_e acc,
   output logic push,
   output logic pop
);
   logic active;

   always_comb begin
      active = !sel_n && !mbx && en;
      acc    = ACC_IDLE;
      if (active) begin
         acc = (dir == PUSH_ON_DIR) ? ACC_PUSH : ACC_POP;
      end
   end

   assign push = (acc == ACC_PUSH);
   assign pop  = (acc == ACC_POP);
endmodule

// File: rtl/bdf_sync.sv
module bdf_sync
   import bdf_pkg::*;
#(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
         $error("bdf_sync: STAGES below minimum");
      end
      if (W < 1) begin : g_bad_width
         $error("bdf_sync: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/bdf_fifo_core.sv
module bdf_fifo_core #(
   parameter int DW          = 36,
   parameter int AW          = 4,
   parameter int AF_OFF      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   output logic          full,
   output logic          afull_n,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          empty
);
   localparam int DEPTH = 1 << AW;
   localparam int PW    = AW + 1;
   localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
   localparam logic [PW-1:0] AF_LVL   = PW'(DEPTH - AF_OFF);

   generate
      if (AF_OFF < 1 || AF_OFF >= DEPTH) begin : g_bad_off
         $error("bdf_fifo_core: AF_OFF must lie in 1..DEPTH-1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("bdf_fifo_core: DW must be positive");
      end
   endgenerate

   function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

   logic [DW-1:0] mem [DEPTH];

   // write domain
   logic [PW-1:0] wbin, wgray, wbin_nx, rgray_s, rbin_s, fill_nx;
   logic          wr_ok, full_q, afn_q;

   bdf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
   );

   always_comb begin
      wr_ok   = push && !full_q;
      wbin_nx = wbin + PW'(wr_ok);
      rbin_s  = g2b(rgray_s);
      fill_nx = wbin_nx - rbin_s;
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         full_q <= 1'b0;
         afn_q  <= 1'b1;
      end else begin
         wbin   <= wbin_nx;
         wgray  <= b2g(wbin_nx);
         full_q <= (fill_nx == FULL_LVL);
         afn_q  <= !(fill_nx >= AF_LVL);
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_ok) begin
         mem[wbin[AW-1:0]] <= din;
      end
   end

   // read domain
   logic [PW-1:0] rbin, rgray, rbin_nx, wgray_s, wbin_s;
   logic          rd_ok, empty_q;
   logic [DW-1:0] dout_q;

   bdf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
   );

   always_comb begin
      rd_ok   = pop && !empty_q;
      rbin_nx = rbin + PW'(rd_ok);
      wbin_s  = g2b(wgray_s);
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         empty_q <= 1'b1;
         dout_q  <= '0;
      end else begin
         rbin    <= rbin_nx;
         rgray   <= b2g(rbin_nx);
         empty_q <= (wbin_s == rbin_nx);
         if (rd_ok) begin
            dout_q <= mem[rbin[AW-1:0]];
         end
      end
   end

   assign full    = full_q;
   assign afull_n = afn_q;
   assign empty   = empty_q;
   assign dout    = dout_q;

   // assertions
   AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
      (wbin - rbin_s) <= FULL_LVL); // R5
   AST_FULL_DROPS_PUSH: assert property (@(posedge wclk) disable iff (!rst_n)
      (full_q && push) |=> $stable(wbin)); // R5
   AST_FULL_IMPLIES_AF: assert property (@(posedge wclk) disable iff (!rst_n)
      full_q |-> !afn_q); // R7
   AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1); // R4
   AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
      (wbin_s - rbin) <= FULL_LVL); // R6
   AST_DOUT_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
      !rd_ok |=> $stable(dout_q)); // R6
endmodule

// File: rtl/bdf_pair.sv
module bdf_pair
   import bdf_pkg::*;
#(
   parameter int DW          = 36,
   parameter int AW          = 4,
   parameter int AF_OFF_AB   = 3,
   parameter int AF_OFF_BA   = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk_a,
   input  logic          clk_b,
   input  logic          rst_n,
   input  logic          a_sel_n,
   input  logic          a_dir,
   input  logic          a_mbx,
   input  logic          a_en,
   input  logic [DW-1:0] a_din,
   output logic [DW-1:0] a_dout,
   output logic          ab_full,
   output logic          ab_afull_n,
   output logic          ba_empty,
   input  logic          b_sel_n,
   input  logic          b_dir,
   input  logic          b_mbx,
   input  logic          b_en,
   input  logic [DW-1:0] b_din,
   output logic [DW-1:0] b_dout,
   output logic          ba_full,
   output logic          ba_afull_n,
   output logic          ab_empty
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 14) begin : g_bad_aw
         $error("bdf_pair: AW out of range");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("bdf_pair: SYNC_STAGES too small");
      end
      if (AF_OFF_AB >= DEPTH || AF_OFF_BA >= DEPTH) begin : g_bad_off
         $error("bdf_pair: almost-full margin must be below DEPTH");
      end
   endgenerate

   acc_e a_acc, b_acc;
   logic a_push, a_pop, b_push, b_pop;

   bdf_port_dec #(.PUSH_ON_DIR(1'b1)) u_dec_a (
      .sel_n(a_sel_n), .dir(a_dir), .mbx(a_mbx), .en(a_en),
      .acc(a_acc), .push(a_push), .pop(a_pop)
   );

   bdf_port_dec #(.PUSH_ON_DIR(1'b0)) u_dec_b (
      .sel_n(b_sel_n), .dir(b_dir), .mbx(b_mbx), .en(b_en),
      .acc(b_acc), .push(b_push), .pop(b_pop)
   );

   bdf_fifo_core #(
      .DW(DW), .AW(AW), .AF_OFF(AF_OFF_AB), .SYNC_STAGES(SYNC_STAGES)
   ) u_fwd (
      .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
      .push(a_push), .din(a_din), .full(ab_full), .afull_n(ab_afull_n),
      .pop(b_pop), .dout(b_dout), .empty(ab_empty)
   );

   bdf_fifo_core #(
      .DW(DW), .AW(AW), .AF_OFF(AF_OFF_BA), .SYNC_STAGES(SYNC_STAGES)
   ) u_ret (
      .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
      .push(b_push), .din(b_din), .full(ba_full), .afull_n(ba_afull_n),
      .pop(a_pop), .dout(a_dout), .empty(ba_empty)
   );

   AST_A_ONE_ACTION: assert property (@(posedge clk_a) disable iff (!rst_n)
      $onehot0({a_push, a_pop})); // R1
   AST_B_ONE_ACTION: assert property (@(posedge clk_b) disable iff (!rst_n)
      $onehot0({b_push, b_pop})); // R2
   AST_A_MBX_BLOCKS: assert property (@(posedge clk_a) disable iff (!rst_n)
      (a_mbx || a_sel_n || !a_en) |-> (a_acc == ACC_IDLE)); // R3
endmodule

// File: tb/bdf_pair_bench.sv
module bdf_pair_bench;
   localparam int DW = 36;
   localparam int AW = 4;
   localparam int D  = 1 << AW;
   localparam int Y_AB = 3;
   localparam int Y_BA = 5;

   logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
   always #2 clk_a = ~clk_a;
   always #3 clk_b = ~clk_b;

   logic          a_sel_n = 1'b1, a_dir = 1'b0, a_mbx = 1'b0, a_en = 1'b0;
   logic          b_sel_n = 1'b1, b_dir = 1'b0, b_mbx = 1'b0, b_en = 1'b0;
   logic [DW-1:0] a_din = '0, b_din = '0;
   logic [DW-1:0] a_dout, b_dout;
   logic          ab_full, ab_afull_n, ba_empty, ba_full, ba_afull_n, ab_empty;

   bdf_pair #(.DW(DW), .AW(AW), .AF_OFF_AB(Y_AB), .AF_OFF_BA(Y_BA)) u_bdf_pair (
      .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
      .a_sel_n(a_sel_n), .a_dir(a_dir), .a_mbx(a_mbx), .a_en(a_en),
      .a_din(a_din), .a_dout(a_dout),
      .ab_full(ab_full), .ab_afull_n(ab_afull_n), .ba_empty(ba_empty),
      .b_sel_n(b_sel_n), .b_dir(b_dir), .b_mbx(b_mbx), .b_en(b_en),
      .b_din(b_din), .b_dout(b_dout),
      .ba_full(ba_full), .ba_afull_n(ba_afull_n), .ab_empty(ab_empty)
   );

   int total = 0, bad = 0;

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input bit port, input logic sel_n, input logic dir,
                        input logic mbx, input logic en, input logic [DW-1:0] d);
      if (!port) begin
         @(negedge clk_a);
         a_sel_n = sel_n; a_dir = dir; a_mbx = mbx; a_en = en; a_din = d;
         @(posedge clk_a); #1;
         a_sel_n = 1'b1; a_mbx = 1'b0; a_en = 1'b0;
      end else begin
         @(negedge clk_b);
         b_sel_n = sel_n; b_dir = dir; b_mbx = mbx; b_en = en; b_din = d;
         @(posedge clk_b); #1;
         b_sel_n = 1'b1; b_mbx = 1'b0; b_en = 1'b0;
      end
   endtask

   // queue f=0 is forward (push on A, pop on B); f=1 is return (push on B, pop on A)
   task automatic push(input int f, input logic [DW-1:0] d);
      drive(f != 0, 1'b0, f == 0, 1'b0, 1'b1, d);
   endtask

   task automatic pop(input int f);
      drive(f == 0, 1'b0, f == 0, 1'b0, 1'b1, '0);
   endtask

   task automatic settle();
      repeat (8) @(negedge clk_a);
      repeat (8) @(negedge clk_b);
   endtask

   function automatic logic afn(input int f);
      return (f == 0) ? ab_afull_n : ba_afull_n;
   endfunction
   function automatic logic fl(input int f);
      return (f == 0) ? ab_full : ba_full;
   endfunction
   function automatic logic em(input int f);
      return (f == 0) ? ab_empty : ba_empty;
   endfunction
   function automatic logic [DW-1:0] dq(input int f);
      return (f == 0) ? b_dout : a_dout;
   endfunction
   function automatic logic [DW-1:0] pat(input int f, input int i);
      return {4'(f + 5), 32'(i) * 32'h9E3779B1 ^ 32'h00C0FFEE};
   endfunction

   task automatic sweep(input int f);
      int y;
      string aft;
      logic [DW-1:0] last;
      y   = (f == 0) ? Y_AB : Y_BA;
      aft = (f == 0) ? "R7" : "R8";
      // dropped accesses on an empty queue: deselected, mailbox, disabled
      drive(f != 0, 1'b1, f == 0, 1'b0, 1'b1, 36'h111);
      drive(f != 0, 1'b0, f == 0, 1'b1, 1'b1, 36'h222);
      drive(f != 0, 1'b0, f == 0, 1'b0, 1'b0, 36'h333);
      settle();
      chk("R3 ignored push leaves empty", DW'(em(f)), DW'(1'b1));
      // fill sweep
      for (int c = 1; c <= D; c++) begin
         push(f, pat(f, c));
         settle();
         chk({aft, " almost-full at fill"}, DW'(afn(f)), DW'(!(c >= D - y)));
         chk("R5 full at fill", DW'(fl(f)), DW'(c == D));
         chk("R6 empty at fill", DW'(em(f)), DW'(1'b0));
      end
      push(f, 36'hBADBADBAD);
      settle();
      chk("R5 full after dropped push", DW'(fl(f)), DW'(1'b1));
      last = dq(f);
      drive(f == 0, 1'b1, f == 0, 1'b0, 1'b1, '0);
      drive(f == 0, 1'b0, f == 0, 1'b1, 1'b1, '0);
      drive(f == 0, 1'b0, f == 0, 1'b0, 1'b0, '0);
      settle();
      chk("R3 ignored pop keeps full", DW'(fl(f)), DW'(1'b1));
      chk("R3 ignored pop keeps dout", dq(f), last);
      // drain sweep
      for (int c = D - 1; c >= 0; c--) begin
         pop(f);
         chk("R1 R2 R4 data order", dq(f), pat(f, D - c));
         if (c == D - y - 1) begin
            int k;
            k = 0;
            while (k < 8 && afn(f) !== 1'b1) begin
               if (f == 0) @(posedge clk_a); else @(posedge clk_b);
               #1;
               k++;
            end
            chk("R9 release within four writer edges", DW'(k <= 4), DW'(1'b1));
         end
         settle();
         chk({aft, " almost-full at drain"}, DW'(afn(f)), DW'(!(c >= D - y)));
         chk("R6 empty at drain", DW'(em(f)), DW'(c == 0));
         chk("R5 full at drain", DW'(fl(f)), DW'(1'b0));
      end
      last = dq(f);
      pop(f);
      chk("R6 pop on empty keeps dout", dq(f), last);
      settle();
      chk("R6 still empty", DW'(em(f)), DW'(1'b1));
   endtask

   task automatic interleave(input int f);
      int wi, ri;
      wi = 0; ri = 0;
      for (int i = 0; i < 3; i++) begin
         wi++; push(f, pat(f, 100 + wi));
      end
      settle();
      for (int i = 0; i < 20; i++) begin
         wi++; push(f, pat(f, 100 + wi));
         pop(f); ri++;
         chk("R4 interleaved order", dq(f), pat(f, 100 + ri));
      end
      settle();
      while (ri < wi) begin
         pop(f); ri++;
         chk("R4 interleaved tail", dq(f), pat(f, 100 + ri));
      end
      settle();
      chk("R6 empty after interleave", DW'(em(f)), DW'(1'b1));
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (4) @(negedge clk_a);
      chk("R10 forward empty in reset", DW'(ab_empty), DW'(1'b1));
      chk("R10 return empty in reset", DW'(ba_empty), DW'(1'b1));
      chk("R10 fulls low in reset", DW'({ab_full, ba_full}), DW'(2'b00));
      chk("R10 almost-full high in reset", DW'({ab_afull_n, ba_afull_n}), DW'(2'b11));
      chk("R10 outputs zero in reset", a_dout | b_dout, '0);
      rst_n = 1'b1;
      settle();
      sweep(0);
      sweep(1);
      interleave(0);
      interleave(1);
      summary();
      $finish;
   end

   initial begin
      #400000;
      total++;
      bad++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      summary();
      $finish;
   end
endmodule